// File: doc/BRIEF.md
# Out-of-Order Instruction Issue Queue

This block holds instructions that have already been renamed and are waiting to run. Each one waits here until both of its physical source operands are known to be produced. The dispatch stage writes one instruction per cycle into a free slot. Each slot records the opcode, the physical destination tag, two physical source tags and one ready flag per source.

When an execution unit finishes, it broadcasts the physical tag it produced on the wakeup port. Every waiting source whose stored tag equals that tag exactly is marked ready. Each cycle the queue sends at most one instruction to a single ALU: the oldest one whose sources are both ready. A younger ready instruction therefore runs ahead of an older one that is still blocked.

Source values are not read here. The issue port carries only the tags, so the register file can be read after selection. A flush input empties the queue in one cycle.

Top module: `issue_queue`

## Requirements
- R1: After reset the queue is empty: `disp_ready` is 1 and `iss_valid` is 0.
- R2: An entry is issued only when both of its source ready flags are set. The issue port then shows the opcode, destination tag and both source tags exactly as dispatched. An issued entry leaves the queue at that clock edge.
- R3: A wakeup (`wk_valid`=1) sets a stored source's ready flag only when `wk_tag` equals that source's tag in every bit. A different tag leaves the entry waiting.
- R4: The ready flags given with a dispatch are stored with it. An entry dispatched with both flags set is issuable in the cycle right after the dispatch edge.
- R5: A wakeup in the same cycle as a dispatch also marks the matching sources of the newly written entry as ready.
- R6: Among all ready entries, the one dispatched earliest is issued, whatever slot it occupies. At most one entry is issued per cycle.
- R7: `flush`=1 invalidates every entry at the next edge. A dispatch offered in the same cycle is discarded.
- R8: `disp_ready` is 0 while all DEPTH (default 8) slots are occupied. A dispatch offered then is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flush | input | 1 | Discard every queued entry |
| disp_valid | input | 1 | Dispatch request |
| disp_ready | output | 1 | A free slot exists |
| disp_op | input | OP_W | Opcode of the dispatched instruction |
| disp_dst | input | TAG_W | Physical destination tag |
| disp_src1 | input | TAG_W | First physical source tag |
| disp_src1_rdy | input | 1 | First source already produced |
| disp_src2 | input | TAG_W | Second physical source tag |
| disp_src2_rdy | input | 1 | Second source already produced |
| wk_valid | input | 1 | Wakeup broadcast present |
| wk_tag | input | TAG_W | Physical tag just produced |
| iss_valid | output | 1 | An instruction is issued this cycle |
| iss_op | output | OP_W | Issued opcode |
| iss_dst | output | TAG_W | Issued destination tag |
| iss_src1 | output | TAG_W | Issued first source tag |
| iss_src2 | output | TAG_W | Issued second source tag |

## Verification
The assertions assume the ALU accepts an issued instruction every cycle, so nothing can hold an issue back. They also assume a dispatch is only counted when `disp_ready` is high. The stimulus never relies on back-pressure at the issue port, and it offers the one over-capacity dispatch only while the queue is known to be full. The stimulus also gives every waiting source a tag distinct from unrelated wakeups, except where a near-miss tag is the point of the test. Expected issue order is then fixed by dispatch order and wakeup timing alone.

// File: rtl/iq_pkg.sv
// Package: default sizes shared by the issue queue modules.
// Assumes: callers may override these through module parameters.
package iq_pkg;
    localparam int unsigned IQ_DEPTH_DEF = 8;
    localparam int unsigned IQ_TAG_W_DEF = 6;
    localparam int unsigned IQ_OP_W_DEF  = 4;
endpackage

// File: rtl/iq_slot.sv
// Module: one issue-queue slot. Stores a renamed instruction and tracks
// readiness of its two physical sources from wakeup broadcasts.
// Assumes: load is only raised for a free slot; clear wins over load.
module iq_slot #(
    parameter int unsigned TAG_W = 6,
    parameter int unsigned OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [OP_W-1:0]  ld_op,
    input  logic [TAG_W-1:0] ld_dst,
    input  logic [TAG_W-1:0] ld_s1,
    input  logic             ld_s1_rdy,
    input  logic [TAG_W-1:0] ld_s2,
    input  logic             ld_s2_rdy,
    input  logic             wk_valid,
    input  logic [TAG_W-1:0] wk_tag,
    output logic             valid,
    output logic             ready,
    output logic [OP_W-1:0]  op,
    output logic [TAG_W-1:0] dst,
    output logic [TAG_W-1:0] s1,
    output logic [TAG_W-1:0] s2
);
    logic s1_rdy, s2_rdy;
    logic hit_ld1, hit_ld2, hit_s1, hit_s2;

    // Exact tag comparison against incoming and stored sources.
    always_comb begin
        hit_ld1 = wk_valid && (wk_tag == ld_s1);
        hit_ld2 = wk_valid && (wk_tag == ld_s2);
        hit_s1  = wk_valid && (wk_tag == s1);
        hit_s2  = wk_valid && (wk_tag == s2);
    end

    // Occupancy flag of the slot.
    always_ff @(posedge clk) begin
        if (!rst_n)     valid <= 1'b0;
        else if (clear) valid <= 1'b0;
        else if (load)  valid <= 1'b1;
    end

    // Capture the instruction, then accumulate wakeups on its sources.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op <= '0; dst <= '0; s1 <= '0; s2 <= '0;
            s1_rdy <= 1'b0; s2_rdy <= 1'b0;
        end else if (load) begin
            op     <= ld_op;
            dst    <= ld_dst;
            s1     <= ld_s1;
            s2     <= ld_s2;
            s1_rdy <= ld_s1_rdy | hit_ld1;
            s2_rdy <= ld_s2_rdy | hit_ld2;
        end else if (valid) begin
            if (hit_s1) s1_rdy <= 1'b1;
            if (hit_s2) s2_rdy <= 1'b1;
        end
    end

    // Slot requests issue when both sources are available.
    assign ready = valid & s1_rdy & s2_rdy;

    a_r3_wake_src1: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear && !load && wk_valid && wk_tag == s1) |=> (valid && s1_rdy));
    a_r3_wake_src2: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && !clear && !load && wk_valid && wk_tag == s2) |=> (valid && s2_rdy));
    a_r5_wake_on_load: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clear && hit_ld1 && hit_ld2) |=> ready);
endmodule

// File: rtl/iq_alloc.sv
// Module: free-slot finder. Picks the lowest-numbered empty slot for the
// next dispatch and reports when none is left.
// Assumes: valid reflects the registered occupancy of every slot.
module iq_alloc #(
    parameter int unsigned DEPTH = 8
) (
    input  logic [DEPTH-1:0] valid,
    output logic [DEPTH-1:0] free_oh,
    output logic             full
);
    // Priority scan for the first free slot.
    always_comb begin
        free_oh = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid[i]) free_oh = DEPTH'(1) << i;
        end
    end

    // Queue is full when every slot is occupied.
    assign full = &valid;
endmodule

// File: rtl/iq_age_pick.sv
// Module: age matrix and oldest-ready selector. older[j][i]=1 records
// that slot j was dispatched before slot i.
// Assumes: alloc is one-hot or zero and names a slot that is empty.
module iq_age_pick #(
    parameter int unsigned DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEPTH-1:0] alloc,
    input  logic [DEPTH-1:0] valid,
    input  logic [DEPTH-1:0] req,
    output logic [DEPTH-1:0] grant
);
    logic [DEPTH-1:0] older [DEPTH];

    // On allocation, the new slot becomes younger than every occupied slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < DEPTH; r++) older[r] <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (alloc[k]) begin
                    older[k] <= '0;
                    for (int j = 0; j < DEPTH; j++) begin
                        if (j != k) older[j][k] <= valid[j];
                    end
                end
            end
        end
    end

    // Grant a requester only if no older slot also requests.
    for (genvar i = 0; i < DEPTH; i++) begin : g_pick
        logic [DEPTH-1:0] older_than_i;
        always_comb begin
            for (int j = 0; j < DEPTH; j++) older_than_i[j] = older[j][i];
        end
        assign grant[i] = req[i] & ~|(req & older_than_i);
    end

    a_r6_single_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    a_r6_grant_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        (|req) |-> (|grant));
endmodule

// File: rtl/issue_queue.sv
// Module: out-of-order issue queue top. Accepts renamed instructions,
// wakes sources on broadcast tags, issues the oldest ready entry.
// Assumes: the single ALU accepts every issued instruction.
module issue_queue #(
    parameter int unsigned DEPTH = iq_pkg::IQ_DEPTH_DEF,
    parameter int unsigned TAG_W = iq_pkg::IQ_TAG_W_DEF,
    parameter int unsigned OP_W  = iq_pkg::IQ_OP_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             disp_valid,
    output logic             disp_ready,
    input  logic [OP_W-1:0]  disp_op,
    input  logic [TAG_W-1:0] disp_dst,
    input  logic [TAG_W-1:0] disp_src1,
    input  logic             disp_src1_rdy,
    input  logic [TAG_W-1:0] disp_src2,
    input  logic             disp_src2_rdy,
    input  logic             wk_valid,
    input  logic [TAG_W-1:0] wk_tag,
    output logic             iss_valid,
    output logic [OP_W-1:0]  iss_op,
    output logic [TAG_W-1:0] iss_dst,
    output logic [TAG_W-1:0] iss_src1,
    output logic [TAG_W-1:0] iss_src2
);
    logic [DEPTH-1:0] valid, ready, free_oh, load, grant;
    logic             full, accept;
    logic [OP_W-1:0]  s_op  [DEPTH];
    logic [TAG_W-1:0] s_dst [DEPTH];
    logic [TAG_W-1:0] s_s1  [DEPTH];
    logic [TAG_W-1:0] s_s2  [DEPTH];

    iq_alloc #(.DEPTH(DEPTH)) u_alloc (
        .valid(valid), .free_oh(free_oh), .full(full)
    );

    // Dispatch handshake; flush discards a same-cycle dispatch.
    assign disp_ready = ~full;
    assign accept     = disp_valid & disp_ready & ~flush;
    assign load       = accept ? free_oh : '0;

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        iq_slot #(.TAG_W(TAG_W), .OP_W(OP_W)) u_slot (
            .clk(clk), .rst_n(rst_n),
            .clear(flush | grant[i]), .load(load[i]),
            .ld_op(disp_op), .ld_dst(disp_dst),
            .ld_s1(disp_src1), .ld_s1_rdy(disp_src1_rdy),
            .ld_s2(disp_src2), .ld_s2_rdy(disp_src2_rdy),
            .wk_valid(wk_valid), .wk_tag(wk_tag),
            .valid(valid[i]), .ready(ready[i]),
            .op(s_op[i]), .dst(s_dst[i]), .s1(s_s1[i]), .s2(s_s2[i])
        );
    end

    iq_age_pick #(.DEPTH(DEPTH)) u_pick (
        .clk(clk), .rst_n(rst_n), .alloc(load),
        .valid(valid), .req(ready), .grant(grant)
    );

    // One-hot mux of the granted slot onto the issue port.
    always_comb begin
        iss_op = '0; iss_dst = '0; iss_src1 = '0; iss_src2 = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (grant[i]) begin
                iss_op   = iss_op   | s_op[i];
                iss_dst  = iss_dst  | s_dst[i];
                iss_src1 = iss_src1 | s_s1[i];
                iss_src2 = iss_src2 | s_s2[i];
            end
        end
    end
    assign iss_valid = |grant;

    a_r7_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (!iss_valid && disp_ready));
    a_r8_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!disp_ready && !flush && !iss_valid) |=> !disp_ready);
    a_r4_ready_dispatch_issues: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && disp_src1_rdy && disp_src2_rdy) |=> iss_valid);
    a_r2_issue_from_valid: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid |-> (|(grant & valid)));
endmodule

// File: tb/issue_queue_tb.sv
module issue_queue_tb;
    localparam int TAG_W = 6;
    localparam int OP_W  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             flush = 1'b0;
    logic             disp_valid = 1'b0;
    logic             disp_ready;
    logic [OP_W-1:0]  disp_op = '0;
    logic [TAG_W-1:0] disp_dst = '0, disp_src1 = '0, disp_src2 = '0;
    logic             disp_src1_rdy = 1'b0, disp_src2_rdy = 1'b0;
    logic             wk_valid = 1'b0;
    logic [TAG_W-1:0] wk_tag = '0;
    logic             iss_valid;
    logic [OP_W-1:0]  iss_op;
    logic [TAG_W-1:0] iss_dst, iss_src1, iss_src2;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    issue_queue u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .disp_valid(disp_valid), .disp_ready(disp_ready),
        .disp_op(disp_op), .disp_dst(disp_dst),
        .disp_src1(disp_src1), .disp_src1_rdy(disp_src1_rdy),
        .disp_src2(disp_src2), .disp_src2_rdy(disp_src2_rdy),
        .wk_valid(wk_valid), .wk_tag(wk_tag),
        .iss_valid(iss_valid), .iss_op(iss_op), .iss_dst(iss_dst),
        .iss_src1(iss_src1), .iss_src2(iss_src2)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic disp(input int op, input int dst, input int s1, input bit r1,
                        input int s2, input bit r2);
        disp_valid = 1'b1;
        disp_op = OP_W'(op); disp_dst = TAG_W'(dst);
        disp_src1 = TAG_W'(s1); disp_src1_rdy = r1;
        disp_src2 = TAG_W'(s2); disp_src2_rdy = r2;
    endtask

    task automatic idle();
        disp_valid = 1'b0; wk_valid = 1'b0; flush = 1'b0;
    endtask

    task automatic wake(input int tag);
        wk_valid = 1'b1; wk_tag = TAG_W'(tag);
    endtask

    task automatic expect_issue(input string req, input int dst);
        chk(iss_valid == 1'b1, req, int'(iss_valid), 1);
        chk(int'(iss_dst) == dst, req, int'(iss_dst), dst);
    endtask

    task automatic expect_none(input string req);
        chk(iss_valid == 1'b0, req, int'(iss_valid), 0);
    endtask

    // R1: empty after reset.
    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(disp_ready == 1'b1, "R1", int'(disp_ready), 1);
        expect_none("R1");
    endtask

    // R2 R4: a fully ready dispatch issues next cycle with its fields.
    task automatic t_basic();
        disp(5, 12, 3, 1'b1, 4, 1'b1);
        tick();
        idle();
        expect_issue("R4", 12);
        chk(int'(iss_op) == 5, "R2", int'(iss_op), 5);
        chk(int'(iss_src1) == 3, "R2", int'(iss_src1), 3);
        chk(int'(iss_src2) == 4, "R2", int'(iss_src2), 4);
        tick();
        expect_none("R2");
    endtask

    // R6 R3: younger ready overtakes blocked older; near tag does not wake.
    task automatic t_overtake();
        disp(1, 20, 5, 1'b0, 2, 1'b1);
        tick();
        idle();
        expect_none("R2");
        disp(2, 21, 7, 1'b1, 8, 1'b1);
        tick();
        idle();
        expect_issue("R6", 21);
        tick();
        expect_none("R2");
        wake(4);
        tick();
        idle();
        expect_none("R3");
        wake(5);
        tick();
        idle();
        expect_issue("R3", 20);
        chk(int'(iss_op) == 1, "R2", int'(iss_op), 1);
        tick();
        expect_none("R2");
    endtask

    // R6: age beats slot position after a slot is reused.
    task automatic t_age();
        disp(3, 30, 1, 1'b0, 0, 1'b1);
        tick();
        disp(3, 31, 2, 1'b0, 0, 1'b1);
        tick();
        idle();
        wake(1);
        tick();
        idle();
        expect_issue("R6", 30);
        tick();
        expect_none("R6");
        disp(3, 32, 9, 1'b1, 2, 1'b0);
        tick();
        idle();
        expect_none("R3");
        wake(2);
        tick();
        idle();
        expect_issue("R6", 31);
        tick();
        expect_issue("R6", 32);
        tick();
        expect_none("R6");
    endtask

    // R5: wakeup and dispatch in the same cycle.
    task automatic t_same_cycle();
        disp(6, 40, 11, 1'b0, 11, 1'b0);
        wake(11);
        tick();
        idle();
        expect_issue("R5", 40);
        tick();
        expect_none("R5");
    endtask

    // R8 R7: fill, reject overflow, flush with dropped dispatch.
    task automatic t_full_flush();
        for (int i = 0; i < 8; i++) begin
            disp(7, 50 + i, 13, 1'b0, 0, 1'b1);
            tick();
        end
        idle();
        chk(disp_ready == 1'b0, "R8", int'(disp_ready), 0);
        disp(7, 60, 1, 1'b1, 1, 1'b1);
        tick();
        idle();
        expect_none("R8");
        chk(disp_ready == 1'b0, "R8", int'(disp_ready), 0);
        flush = 1'b1;
        disp(7, 61, 1, 1'b1, 1, 1'b1);
        tick();
        idle();
        chk(disp_ready == 1'b1, "R7", int'(disp_ready), 1);
        expect_none("R7");
        wake(13);
        tick();
        idle();
        expect_none("R7");
        tick();
        expect_none("R7");
    endtask

    initial begin
        t_reset();
        t_basic();
        t_overtake();
        t_age();
        t_same_cycle();
        t_full_flush();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule